// File: doc/BRIEF.md
# Display-Memory Serial Target

This block is an I2C target that sits in front of the small memory of a status-panel display driver. A host on the two-wire bus writes a control byte, then a run of data bytes into a twelve-byte store. It can read the store back either after setting a new start position in the same transfer or straight from the position it already holds. The control byte also carries the display-wide settings: blanking, frame-rate choice and blink-rate choice. These are offered to the display engine as plain levels. The engine reads the store through its own combinational port.

Both bus lines are oversampled by the system clock. Each passes a two-flop synchronizer and is then compared with its previous sample, which yields the start, stop, rising-SCL and falling-SCL events. SDA is open-drain. The block only asks for the line to be pulled low, and it changes that request only while SCL is low. The store holds segment bytes at positions 0 to 5 and blink-enable bytes at positions 6 to 11. The last byte of each half has only four meaningful bits.

The controller is a seven-state machine:
- IDLE waits for a start.
- ADDR shifts in the address byte. On a match it goes to ADDR_ACK. On a mismatch it returns to IDLE with SDA released.
- ADDR_ACK moves to RX for a write or TX for a read.
- RX takes in a byte and then goes to RX_ACK. RX_ACK returns to RX.
- TX sends a byte and then goes to TX_ACK. TX_ACK goes back to TX when the host acknowledges, or to IDLE when it does not.
- A start from any state goes to ADDR. A stop from any state goes to IDLE.

Top module: `segpanel_i2c_target`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) only an address byte whose upper seven bits equal the parameter `DEV_ADDR` (default 7'b0111001). For any other address it leaves SDA released and the settings stay unchanged. SDA changes only while the synchronized SCL is low.
- R2: In a write transfer the first byte after the address is the control byte. Bit 7 drives `blank_o`, bits 6:5 drive `frame_sel_o`, bit 4 drives `blink_sel_o` and bits 3:0 set the pointer `ptr_o`.
- R3: Every further written byte is stored at the pointer, and the pointer then advances by one, until a stop.
- R4: The pointer runs from 0 to 11 and steps from 11 back to 0, both for writes and for reads.
- R5: A control byte whose pointer field is 12 to 15 sets the pointer to 0.
- R6: A read transfer sends stored bytes MSB first, starting at the pointer and advancing it after each byte. After the host answers a byte with NACK, SDA stays released.
- R7: A read that is not preceded by a control byte in the same transfer starts from the pointer already held.
- R8: Reset clears all control settings and the pointer to 0, and every stored byte to 0x00.
- R9: Positions 5 and 11 keep only the low four bits of a written byte. Their upper four bits always read 0.
- R10: `eng_data_o` shows the stored byte at `eng_addr_i` in the same cycle, and 0x00 for addresses 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 asks the pad to pull SDA low |
| blank_o | output | 1 | Display blanking setting |
| frame_sel_o | output | 2 | Frame-rate choice |
| blink_sel_o | output | 1 | Blink-rate choice |
| ptr_o | output | 4 | Current memory pointer |
| eng_addr_i | input | 4 | Display engine read address |
| eng_data_o | output | 8 | Display engine read data |

## Verification
Every bus event reaches the state machine three system clocks after the line moves: two synchronizer flops, then the compare register. The SDA pull request therefore changes about three cycles after the master lowers SCL. The bench holds each SCL phase for sixteen cycles and samples SDA eight cycles into the high phase, well clear of that delay. Settings, pointer and stored bytes are updated on the SCL fall that ends a byte, so the bench reads them through the ports only after the whole transfer has ended with a stop.

// File: rtl/segpanel_pkg.sv
package segpanel_pkg;

    localparam int MEM_DEPTH = 12;
    localparam int PTR_W     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } xfer_state_t;

    function automatic logic [PTR_W-1:0] ptr_clamp(input logic [PTR_W-1:0] p);
        return (p < PTR_W'(MEM_DEPTH)) ? p : '0;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(MEM_DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/segpanel_busmon.sv
module segpanel_busmon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl  = scl_sh[STAGES-1];
    assign sda_lvl  = sda_sh[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;
    assign start_c  = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_c   = scl_lvl & scl_d & ~sda_d & sda_lvl;

    // R1: a bus condition never coincides with an SCL edge
    p_events_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start_c, stop_c}));

endmodule

// File: rtl/segpanel_store.sv
module segpanel_store
    import segpanel_pkg::*;
#(
    parameter int DEPTH = MEM_DEPTH,
    parameter int AW    = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] haddr,
    output logic [7:0]    hdata,
    input  logic [AW-1:0] eaddr,
    output logic [7:0]    edata
);
    localparam int HALF = DEPTH / 2;

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam bit NIBBLE_ONLY = (g == HALF - 1) || (g == DEPTH - 1);
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '0;
            else if (we && waddr == AW'(g))
                cell_q <= NIBBLE_ONLY ? {4'h0, wdata[3:0]} : wdata;
        end
        assign cells[g] = cell_q;
    end

    always_comb begin
        hdata = '0;
        edata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (haddr == AW'(i)) hdata = cells[i];
            if (eaddr == AW'(i)) edata = cells[i];
        end
    end

    // R9: the short positions never show upper bits
    p_short_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eaddr == AW'(HALF - 1) || eaddr == AW'(DEPTH - 1)) |-> (edata[7:4] == 4'h0));

    // R10: out-of-range engine addresses read as zero
    p_engine_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eaddr >= AW'(DEPTH)) |-> (edata == 8'h00));

endmodule

// File: rtl/segpanel_ctrl.sv
module segpanel_ctrl
    import segpanel_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0111001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_c,
    input  logic             stop_c,
    input  logic [7:0]       rd_byte,
    output logic             sda_pull,
    output logic [7:0]       cmd_q,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_waddr,
    output logic [7:0]       mem_wdata
);
    xfer_state_t state, state_nx;
    logic [7:0]  sr;
    logic [3:0]  bitcnt;
    logic        rw_q, got_cmd, ack_q;
    logic        byte_done, addr_hit, cmd_ld;

    assign byte_done = (bitcnt == 4'd8);
    assign addr_hit  = (sr[7:1] == DEV_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (stop_c)
            state_nx = ST_IDLE;
        else if (start_c)
            state_nx = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_nx = rw_q ? ST_TX : ST_RX;
                ST_RX:       if (scl_fall && byte_done) state_nx = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_nx = ST_RX;
                ST_TX:       if (scl_fall && byte_done) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_nx = ack_q ? ST_TX : ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // write strobes toward the store and the control byte
    always_comb begin
        mem_we    = (state == ST_RX) && scl_fall && byte_done && got_cmd;
        cmd_ld    = (state == ST_RX) && scl_fall && byte_done && !got_cmd;
        mem_waddr = cmd_q[PTR_W-1:0];
        mem_wdata = sr;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr       <= '0;
            bitcnt   <= '0;
            rw_q     <= 1'b0;
            got_cmd  <= 1'b0;
            ack_q    <= 1'b0;
            sda_pull <= 1'b0;
            cmd_q    <= '0;
        end else if (start_c || stop_c) begin
            bitcnt   <= '0;
            got_cmd  <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        sr     <= {sr[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (scl_fall && byte_done) begin
                        if (state == ST_ADDR) begin
                            rw_q     <= sr[0];
                            sda_pull <= addr_hit;
                        end else begin
                            sda_pull <= 1'b1;
                            got_cmd  <= 1'b1;
                            if (cmd_ld)
                                cmd_q <= {sr[7:4], ptr_clamp(sr[3:0])};
                            else
                                cmd_q[PTR_W-1:0] <= ptr_step(cmd_q[PTR_W-1:0]);
                        end
                    end
                end
                ST_ADDR_ACK, ST_RX_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR_ACK && rw_q) begin
                            sr       <= rd_byte;
                            sda_pull <= ~rd_byte[7];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) bitcnt <= bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (byte_done) begin
                            sda_pull         <= 1'b0;
                            cmd_q[PTR_W-1:0] <= ptr_step(cmd_q[PTR_W-1:0]);
                        end else begin
                            sr       <= {sr[6:0], 1'b0};
                            sda_pull <= ~sr[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) ack_q <= ~sda_lvl;
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (ack_q) begin
                            sr       <= rd_byte;
                            sda_pull <= ~rd_byte[7];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: the pull request moves only while SCL is low
    p_sda_low_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !$past(scl_lvl));

    // R1: a foreign address leaves the line released
    p_foreign_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && byte_done && !addr_hit) |=> !sda_pull);

    // R3: a stored byte advances the pointer by one
    p_ptr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr != PTR_W'(MEM_DEPTH - 1)) |=> (cmd_q[PTR_W-1:0] == $past(mem_waddr) + PTR_W'(1)));

    // R4: the last position steps back to zero
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_waddr == PTR_W'(MEM_DEPTH - 1)) |=> (cmd_q[PTR_W-1:0] == '0));

    // R5: the pointer never leaves the store
    p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[PTR_W-1:0] < PTR_W'(MEM_DEPTH));

    // R6: a host NACK ends sending with SDA released
    p_nack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_fall && !ack_q) |=> (!sda_pull && state == ST_IDLE));

endmodule

// File: rtl/segpanel_i2c_target.sv
module segpanel_i2c_target
    import segpanel_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0111001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       blank_o,
    output logic [1:0] frame_sel_o,
    output logic       blink_sel_o,
    output logic [3:0] ptr_o,
    input  logic [3:0] eng_addr_i,
    output logic [7:0] eng_data_o
);
    logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
    logic [7:0]       rd_byte, cmd_q, mem_wdata;
    logic             mem_we;
    logic [PTR_W-1:0] mem_waddr;

    segpanel_busmon #(.STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
    );

    segpanel_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
        .stop_c(stop_c), .rd_byte(rd_byte), .sda_pull(sda_pull_o),
        .cmd_q(cmd_q), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    segpanel_store #(.DEPTH(MEM_DEPTH), .AW(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .haddr(cmd_q[PTR_W-1:0]), .hdata(rd_byte),
        .eaddr(eng_addr_i), .edata(eng_data_o)
    );

    assign blank_o     = cmd_q[7];
    assign frame_sel_o = cmd_q[6:5];
    assign blink_sel_o = cmd_q[4];
    assign ptr_o       = cmd_q[3:0];

endmodule

// File: tb/sim_segpanel_i2c_target.sv
module sim_segpanel_i2c_target;

    localparam int         H   = 16;
    localparam logic [6:0] DEV = 7'b0111001;

    // {control byte, data byte, pointer afterwards, byte read back}
    localparam logic [27:0] VEC [5] = '{
        {8'h00, 8'hA5, 4'h1, 8'hA5},
        {8'h25, 8'h3C, 4'h6, 8'h0C},
        {8'h4B, 8'h77, 4'h0, 8'h07},
        {8'hDE, 8'h81, 4'h1, 8'h81},
        {8'h66, 8'hF0, 4'h7, 8'hF0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] eng_addr = 4'h0;
    logic       sda_pull, blank, blink;
    logic [1:0] frame;
    logic [3:0] ptr;
    logic [7:0] eng_data;
    wire        sda_line = m_sda & ~sda_pull;

    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic       released;

    always #2 clk = ~clk;

    segpanel_i2c_target #(.DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .blank_o(blank), .frame_sel_o(frame),
        .blink_sel_o(blink), .ptr_o(ptr), .eng_addr_i(eng_addr),
        .eng_data_o(eng_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H / 2);
        b = sda_line; tick(H / 2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic send_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~send_ack);
    endtask

    task automatic wr_xfer(input logic [6:0] a, input logic [7:0] cmd, input int n, output logic acked);
        logic k;
        bus_start();
        put_byte({a, 1'b0}, acked);
        if (acked) begin
            put_byte(cmd, k);
            for (int i = 0; i < n; i++) put_byte(wbuf[i], k);
        end
        bus_stop();
    endtask

    task automatic rd_xfer(input logic with_cmd, input logic [7:0] cmd, input int n);
        logic k;
        bus_start();
        if (with_cmd) begin
            put_byte({DEV, 1'b0}, k);
            put_byte(cmd, k);
            bus_start();
        end
        put_byte({DEV, 1'b1}, k);
        for (int i = 0; i < n; i++) get_byte(rbuf[i], i != n - 1);
        tick(8);
        released = sda_line;
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic ack;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R8: reset state of settings and store
        check("R8 settings", {blank, frame, blink, ptr}, 32'h0);
        for (int i = 0; i < 12; i++) begin
            eng_addr = 4'(i); #1;
            check("R8 store", eng_data, 32'h0);
        end

        // table walk: R2 fields, R3/R4/R5 pointer, R6 combined read, R9 short slot
        for (int v = 0; v < 5; v++) begin
            wbuf[0] = VEC[v][19:12];
            wr_xfer(DEV, VEC[v][27:20], 1, ack);
            check("R1 address ack", ack, 1);
            check("R2 control fields", {blank, frame, blink}, VEC[v][27:24]);
            check("R3 R4 R5 pointer after write", ptr, VEC[v][11:8]);
            rd_xfer(1'b1, VEC[v][27:20], 1);
            check("R6 combined read byte", rbuf[0], VEC[v][7:0]);
            check("R6 pointer after read", ptr, VEC[v][11:8]);
            check("R6 released after NACK", released, 1);
        end

        // R1: foreign address is refused and changes nothing
        wbuf[0] = 8'h99;
        wr_xfer(7'h3A, 8'h80, 1, ack);
        check("R1 foreign address nack", ack, 0);
        check("R1 settings unchanged", {blank, frame, blink, ptr}, {4'h6, 4'h7});

        // R3 R4 R9: burst across the end of the store
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        wr_xfer(DEV, 8'h09, 6, ack);
        check("R3 burst pointer", ptr, 3);
        eng_addr = 4'h9; #1; check("R3 store at 9", eng_data, 8'h11);
        eng_addr = 4'hB; #1; check("R9 store at 11 masked", eng_data, 8'h03);
        eng_addr = 4'h0; #1; check("R4 wrapped store at 0", eng_data, 8'h44);
        eng_addr = 4'h2; #1; check("R4 store at 2", eng_data, 8'h66);

        // R7: read from the held pointer without a control byte
        wr_xfer(DEV, 8'h01, 0, ack);
        check("R2 pointer only", ptr, 1);
        rd_xfer(1'b0, 8'h00, 2);
        check("R7 direct read first", rbuf[0], 8'h55);
        check("R7 direct read second", rbuf[1], 8'h66);
        check("R7 pointer after read", ptr, 3);

        // R4: read wraps from 11 to 0
        wr_xfer(DEV, 8'h0B, 0, ack);
        rd_xfer(1'b0, 8'h00, 2);
        check("R4 read at 11", rbuf[0], 8'h03);
        check("R4 read wraps to 0", rbuf[1], 8'h44);
        check("R4 pointer after wrap", ptr, 1);

        // R10: engine port beyond the store
        eng_addr = 4'hC; #1; check("R10 engine addr 12", eng_data, 8'h00);
        eng_addr = 4'hF; #1; check("R10 engine addr 15", eng_data, 8'h00);
        eng_addr = 4'h6; #1; check("R10 engine addr 6", eng_data, 8'hF0);

        // R8: reset again mid-life
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(5);
        check("R8 settings after reset", {blank, frame, blink, ptr}, 32'h0);
        eng_addr = 4'h9; #1; check("R8 store after reset", eng_data, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule